// File: doc/BRIEF.md
# Operand Effective Address Generator

This block turns the operand-addressing information of an 8-bit accumulator machine into the address that the memory system needs. The decoder supplies a 3-bit mode code, the instruction's 3-bit register field, the operand byte (and a second byte for wide immediates), the two bank-select bits of the status word, the contents of the two pointer registers, the 16-bit data pointer and the accumulator. From these the block produces one of four results. The first is an internal RAM address. The second is an external data address. The third is a code-memory address. The fourth is an immediate constant. Each result comes with its own valid flag.

The working registers form a banked window. Four banks of eight registers sit at the bottom of internal RAM, and the status-word bits choose the active bank. Only the first two registers of the active bank may serve as indirect pointers. A code-table address is the data pointer plus the unsigned accumulator. Combinations the machine does not allow raise an error flag instead of a valid result.

All results are registered once, so they appear one clock after the inputs. Any result whose valid flag is low is driven to zero.

Top module: `eag_top`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it, every output is zero.
- R2: Mode 0 (register) with `pair_reg_i` low gives `iram_vld_o`=1 and `iram_addr_o` = {2'b00... bank_i[1:0], rsel_i[2:0]}. The bank bits sit at address bits 4:3 and the register number at bits 2:0, so the banks fill addresses 00h to 1Fh.
- R3: Mode 1 (direct) gives `iram_vld_o`=1 with `iram_addr_o` equal to `opnd_i`.
- R4: Mode 2 (internal indirect) with `rsel_i` equal to 0 or 1 gives `iram_vld_o`=1, and `iram_addr_o` is `ptr0_i` or `ptr1_i` respectively.
- R5: Mode 2 or mode 3 with `rsel_i` from 2 to 7 gives `err_o`=1 and no valid flag.
- R6: Mode 3 (external through a pointer register) with `rsel_i` equal to 0 or 1 gives `xdata_vld_o`=1 and `xdata_addr_o` = {8'h00, selected pointer}.
- R7: Mode 4 (external through the data pointer) gives `xdata_vld_o`=1 with `xdata_addr_o` equal to `dptr_i`.
- R8: Mode 5 (indexed code) gives `code_vld_o`=1 with `code_addr_o` = (`dptr_i` + `acc_i`) mod 2^16. The accumulator is unsigned.
- R9: Mode 6 (short immediate) gives `imm_vld_o`=1 with `imm_data_o` = {8'h00, `opnd_i`} and no address valid.
- R10: Mode 7 (wide immediate for a data-pointer load) gives `imm_vld_o`=1 with `imm_data_o` = {`opnd_hi_i`, `opnd_i`}.
- R11: Mode 0 with `pair_reg_i` high, which marks a register-to-register move, gives `err_o`=1 and no valid flag.
- R12: At most one valid flag is high in any cycle. Every output whose flag is low is zero. `pair_reg_i` has no effect outside mode 0. Results appear exactly one clock after their inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 3 | Addressing mode code (0 to 7, see requirements) |
| rsel_i | input | 3 | Register field of the instruction |
| bank_i | input | 2 | Active register bank from the status word |
| pair_reg_i | input | 1 | Other operand is also a working register |
| opnd_i | input | 8 | Operand byte |
| opnd_hi_i | input | 8 | High byte for a wide immediate |
| ptr0_i | input | 8 | Content of pointer register 0 |
| ptr1_i | input | 8 | Content of pointer register 1 |
| dptr_i | input | 16 | Data pointer |
| acc_i | input | 8 | Accumulator |
| iram_addr_o | output | 8 | Internal RAM address |
| iram_vld_o | output | 1 | Internal address valid |
| xdata_addr_o | output | 16 | External data address |
| xdata_vld_o | output | 1 | External address valid |
| code_addr_o | output | 16 | Code-memory address |
| code_vld_o | output | 1 | Code address valid |
| imm_data_o | output | 16 | Immediate constant |
| imm_vld_o | output | 1 | Immediate valid |
| err_o | output | 1 | Illegal combination |

## Verification
The assertions assume that the inputs are stable across each rising edge and never unknown once reset is released, because every property compares an output with the inputs one edge earlier. They also ignore the first edge after reset by requiring that the previous cycle was out of reset. The bench drives all inputs on the falling edge, so each edge sees one settled value. It mixes directed corner cases with pseudo-random words that cover every mode, every register number, both values of `pair_reg_i` and data-pointer values near the top of the address space.

// File: rtl/eag_pkg.sv
// eag_pkg: shared addressing-mode encoding for the effective address generator.
// Assumes a 3-bit mode code supplied by the instruction decoder.
package eag_pkg;
    typedef enum logic [2:0] {
        AM_REG   = 3'd0,
        AM_DIR   = 3'd1,
        AM_IND   = 3'd2,
        AM_XIND  = 3'd3,
        AM_XDP   = 3'd4,
        AM_CIDX  = 3'd5,
        AM_IMM8  = 3'd6,
        AM_IMM16 = 3'd7
    } amode_e;

    localparam int BANK_W = 2;
    localparam int RSEL_W = 3;
endpackage

// File: rtl/eag_bank_map.sv
// eag_bank_map: maps the active bank and a register number onto the
// internal RAM address of that working register.
// Assumes DW >= BANK_W + RSEL_W, so the whole bank window fits.
module eag_bank_map
    import eag_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [BANK_W-1:0] bank_i,
    input  logic [RSEL_W-1:0] rsel_i,
    output logic [DW-1:0]     addr_o
);
    localparam int WIN_W = BANK_W + RSEL_W;

    // Concatenate bank and register number, zero-extended to the address width.
    always_comb begin
        addr_o = '0;
        addr_o[WIN_W-1:0] = {bank_i, rsel_i};
    end
endmodule

// File: rtl/eag_ptr_pick.sv
// eag_ptr_pick: selects one of the two pointer registers for indirect
// access. It flags as illegal any register number other than 0 or 1.
// Assumes pointer contents are already read from the active bank.
module eag_ptr_pick
    import eag_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [RSEL_W-1:0] rsel_i,
    input  logic [DW-1:0]     ptr0_i,
    input  logic [DW-1:0]     ptr1_i,
    output logic [DW-1:0]     ptr_o,
    output logic              ok_o
);
    // Choose the pointer and judge the legality of the register field.
    always_comb begin
        ok_o  = (rsel_i[RSEL_W-1:1] == '0);
        ptr_o = rsel_i[0] ? ptr1_i : ptr0_i;
    end
endmodule

// File: rtl/eag_code_idx.sv
// eag_code_idx: forms a code-table address as the base plus an unsigned
// byte index. A carry out of the top bit is discarded (modulo 2^AW).
// Assumes AW > DW.
module eag_code_idx #(
    parameter int DW = 8,
    parameter int AW = 16
) (
    input  logic [AW-1:0] base_i,
    input  logic [DW-1:0] idx_i,
    output logic [AW-1:0] addr_o
);
    // Zero-extend the index and add it with a wrapping sum.
    always_comb begin
        addr_o = base_i + AW'(idx_i);
    end
endmodule

// File: rtl/eag_top.sv
// eag_top: operand effective address generator. It decodes the mode code
// into one of four results (internal, external, code address or immediate),
// or into an error, and registers the result once.
// Assumes AW == 2*DW, so a wide immediate fills the immediate output.
module eag_top
    import eag_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode_i,
    input  logic [RSEL_W-1:0] rsel_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic              pair_reg_i,
    input  logic [DW-1:0]     opnd_i,
    input  logic [DW-1:0]     opnd_hi_i,
    input  logic [DW-1:0]     ptr0_i,
    input  logic [DW-1:0]     ptr1_i,
    input  logic [AW-1:0]     dptr_i,
    input  logic [DW-1:0]     acc_i,
    output logic [DW-1:0]     iram_addr_o,
    output logic              iram_vld_o,
    output logic [AW-1:0]     xdata_addr_o,
    output logic              xdata_vld_o,
    output logic [AW-1:0]     code_addr_o,
    output logic              code_vld_o,
    output logic [AW-1:0]     imm_data_o,
    output logic              imm_vld_o,
    output logic              err_o
);
    logic [DW-1:0] reg_addr;
    logic [DW-1:0] ptr_val;
    logic          ptr_ok;
    logic [AW-1:0] cidx_addr;

    logic [DW-1:0] n_iram;
    logic          n_iram_v;
    logic [AW-1:0] n_xdata;
    logic          n_xdata_v;
    logic [AW-1:0] n_code;
    logic          n_code_v;
    logic [AW-1:0] n_imm;
    logic          n_imm_v;
    logic          n_err;

    eag_bank_map #(.DW(DW)) u_bank (
        .bank_i (bank_i),
        .rsel_i (rsel_i),
        .addr_o (reg_addr)
    );

    eag_ptr_pick #(.DW(DW)) u_ptr (
        .rsel_i (rsel_i),
        .ptr0_i (ptr0_i),
        .ptr1_i (ptr1_i),
        .ptr_o  (ptr_val),
        .ok_o   (ptr_ok)
    );

    eag_code_idx #(.DW(DW), .AW(AW)) u_cidx (
        .base_i (dptr_i),
        .idx_i  (acc_i),
        .addr_o (cidx_addr)
    );

    // Decode the mode into exactly one result or an error; unused results stay zero.
    always_comb begin
        n_iram    = '0;
        n_iram_v  = 1'b0;
        n_xdata   = '0;
        n_xdata_v = 1'b0;
        n_code    = '0;
        n_code_v  = 1'b0;
        n_imm     = '0;
        n_imm_v   = 1'b0;
        n_err     = 1'b0;
        case (amode_e'(mode_i))
            AM_REG: begin
                if (pair_reg_i) begin
                    n_err = 1'b1;
                end else begin
                    n_iram   = reg_addr;
                    n_iram_v = 1'b1;
                end
            end
            AM_DIR: begin
                n_iram   = opnd_i;
                n_iram_v = 1'b1;
            end
            AM_IND: begin
                if (ptr_ok) begin
                    n_iram   = ptr_val;
                    n_iram_v = 1'b1;
                end else begin
                    n_err = 1'b1;
                end
            end
            AM_XIND: begin
                if (ptr_ok) begin
                    n_xdata   = AW'(ptr_val);
                    n_xdata_v = 1'b1;
                end else begin
                    n_err = 1'b1;
                end
            end
            AM_XDP: begin
                n_xdata   = dptr_i;
                n_xdata_v = 1'b1;
            end
            AM_CIDX: begin
                n_code   = cidx_addr;
                n_code_v = 1'b1;
            end
            AM_IMM8: begin
                n_imm   = AW'(opnd_i);
                n_imm_v = 1'b1;
            end
            AM_IMM16: begin
                n_imm   = AW'({opnd_hi_i, opnd_i});
                n_imm_v = 1'b1;
            end
            default: n_err = 1'b1;
        endcase
    end

    // Register the decoded result; synchronous active-low reset clears all.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iram_addr_o  <= '0;
            iram_vld_o   <= 1'b0;
            xdata_addr_o <= '0;
            xdata_vld_o  <= 1'b0;
            code_addr_o  <= '0;
            code_vld_o   <= 1'b0;
            imm_data_o   <= '0;
            imm_vld_o    <= 1'b0;
            err_o        <= 1'b0;
        end else begin
            iram_addr_o  <= n_iram;
            iram_vld_o   <= n_iram_v;
            xdata_addr_o <= n_xdata;
            xdata_vld_o  <= n_xdata_v;
            code_addr_o  <= n_code;
            code_vld_o   <= n_code_v;
            imm_data_o   <= n_imm;
            imm_vld_o    <= n_imm_v;
            err_o        <= n_err;
        end
    end
endmodule

// File: rtl/eag_chk.sv
// eag_chk: property checker for eag_top, attached with bind.
// Assumes the inputs are settled at each rising edge once reset is released.
module eag_chk
    import eag_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        mode_i,
    input logic [RSEL_W-1:0] rsel_i,
    input logic [BANK_W-1:0] bank_i,
    input logic              pair_reg_i,
    input logic [DW-1:0]     opnd_i,
    input logic [DW-1:0]     ptr0_i,
    input logic [AW-1:0]     dptr_i,
    input logic [DW-1:0]     acc_i,
    input logic [DW-1:0]     iram_addr_o,
    input logic              iram_vld_o,
    input logic              xdata_vld_o,
    input logic [AW-1:0]     code_addr_o,
    input logic              code_vld_o,
    input logic              imm_vld_o,
    input logic              err_o
);
    // R12
    one_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({iram_vld_o, xdata_vld_o, code_vld_o, imm_vld_o, err_o}));

    // R2
    reg_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode_i == 3'd0 && !pair_reg_i)) |->
        (iram_vld_o && iram_addr_o == DW'({$past(bank_i), $past(rsel_i)})));

    // R3
    direct_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode_i == 3'd1)) |->
        (iram_vld_o && iram_addr_o == $past(opnd_i)));

    // R4
    ind_ptr0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode_i == 3'd2 && rsel_i == 3'd0)) |->
        (iram_vld_o && iram_addr_o == $past(ptr0_i)));

    // R5
    bad_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past((mode_i == 3'd2 || mode_i == 3'd3) && rsel_i[2:1] != 2'b00)) |->
        (err_o && !iram_vld_o && !xdata_vld_o));

    // R8
    code_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode_i == 3'd5)) |->
        (code_vld_o && code_addr_o == AW'($past(dptr_i) + AW'($past(acc_i)))));

    // R11
    pair_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(mode_i == 3'd0 && pair_reg_i)) |->
        (err_o && !iram_vld_o));
endmodule

bind eag_top eag_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_i),
    .rsel_i      (rsel_i),
    .bank_i      (bank_i),
    .pair_reg_i  (pair_reg_i),
    .opnd_i      (opnd_i),
    .ptr0_i      (ptr0_i),
    .dptr_i      (dptr_i),
    .acc_i       (acc_i),
    .iram_addr_o (iram_addr_o),
    .iram_vld_o  (iram_vld_o),
    .xdata_vld_o (xdata_vld_o),
    .code_addr_o (code_addr_o),
    .code_vld_o  (code_vld_o),
    .imm_vld_o   (imm_vld_o),
    .err_o       (err_o)
);

// File: tb/sim_eag_top.sv
// sim_eag_top: bench for eag_top. A behavioural model predicts every
// output one clock after the inputs and compares on every falling edge.
module sim_eag_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode_i = '0;
    logic [2:0]  rsel_i = '0;
    logic [1:0]  bank_i = '0;
    logic        pair_reg_i = 1'b0;
    logic [7:0]  opnd_i = '0;
    logic [7:0]  opnd_hi_i = '0;
    logic [7:0]  ptr0_i = '0;
    logic [7:0]  ptr1_i = '0;
    logic [15:0] dptr_i = '0;
    logic [7:0]  acc_i = '0;
    logic [7:0]  iram_addr_o;
    logic        iram_vld_o;
    logic [15:0] xdata_addr_o;
    logic        xdata_vld_o;
    logic [15:0] code_addr_o;
    logic        code_vld_o;
    logic [15:0] imm_data_o;
    logic        imm_vld_o;
    logic        err_o;

    int   n_tests = 0;
    int   n_fail  = 0;
    bit   finished = 0;
    bit   pending = 0;
    logic [60:0] exp_vec;
    string       exp_tag;

    always #4 clk = ~clk;

    eag_top u0 (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .rsel_i(rsel_i),
        .bank_i(bank_i), .pair_reg_i(pair_reg_i), .opnd_i(opnd_i),
        .opnd_hi_i(opnd_hi_i), .ptr0_i(ptr0_i), .ptr1_i(ptr1_i),
        .dptr_i(dptr_i), .acc_i(acc_i), .iram_addr_o(iram_addr_o),
        .iram_vld_o(iram_vld_o), .xdata_addr_o(xdata_addr_o),
        .xdata_vld_o(xdata_vld_o), .code_addr_o(code_addr_o),
        .code_vld_o(code_vld_o), .imm_data_o(imm_data_o),
        .imm_vld_o(imm_vld_o), .err_o(err_o)
    );

    function automatic logic [60:0] actual();
        return {iram_addr_o, iram_vld_o, xdata_addr_o, xdata_vld_o,
                code_addr_o, code_vld_o, imm_data_o, imm_vld_o, err_o};
    endfunction

    // Behavioural prediction from the requirement text, using integers.
    task automatic predict();
        int ia = 0, iv = 0, xa = 0, xv = 0, ca = 0, cv = 0, im = 0, mv = 0, er = 0;
        int r = int'(rsel_i);
        int p = (r == 0) ? int'(ptr0_i) : int'(ptr1_i);
        case (int'(mode_i))
            0: begin if (pair_reg_i) begin er = 1; exp_tag = "R11"; end
                     else begin ia = int'(bank_i) * 8 + r; iv = 1; exp_tag = "R2"; end end
            1: begin ia = int'(opnd_i); iv = 1; exp_tag = "R3"; end
            2: begin if (r > 1) begin er = 1; exp_tag = "R5"; end
                     else begin ia = p; iv = 1; exp_tag = "R4"; end end
            3: begin if (r > 1) begin er = 1; exp_tag = "R5"; end
                     else begin xa = p; xv = 1; exp_tag = "R6"; end end
            4: begin xa = int'(dptr_i); xv = 1; exp_tag = "R7"; end
            5: begin ca = (int'(dptr_i) + int'(acc_i)) % 65536; cv = 1; exp_tag = "R8"; end
            6: begin im = int'(opnd_i); mv = 1; exp_tag = "R9"; end
            default: begin im = int'(opnd_hi_i) * 256 + int'(opnd_i); mv = 1; exp_tag = "R10"; end
        endcase
        if (pair_reg_i && mode_i != 3'd0) exp_tag = {exp_tag, "/R12"};
        exp_vec = {ia[7:0], iv[0], xa[15:0], xv[0], ca[15:0], cv[0], im[15:0], mv[0], er[0]};
    endtask

    task automatic check(string tag, logic [60:0] act, logic [60:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle: compare the previous prediction, then drive and predict anew.
    task automatic step(input logic [2:0] m, input logic [2:0] rs, input logic [1:0] bk,
                        input logic pr, input logic [7:0] op, input logic [7:0] oh,
                        input logic [7:0] p0, input logic [7:0] p1,
                        input logic [15:0] dp, input logic [7:0] ac);
        @(negedge clk);
        if (pending) check(exp_tag, actual(), exp_vec);
        mode_i = m; rsel_i = rs; bank_i = bk; pair_reg_i = pr; opnd_i = op;
        opnd_hi_i = oh; ptr0_i = p0; ptr1_i = p1; dptr_i = dp; acc_i = ac;
        predict();
        pending = 1;
    endtask

    initial begin
        // R1: reset with busy inputs must hold every output at zero.
        mode_i = 3'd5; dptr_i = 16'h1234; acc_i = 8'h11; opnd_i = 8'h5A;
        repeat (3) @(negedge clk);
        check("R1", actual(), 61'd0);
        rst_n = 1'b1;
        mode_i = 3'd0; dptr_i = '0; acc_i = '0; opnd_i = '0;
        exp_vec = {8'h00, 1'b1, 16'h0, 1'b0, 16'h0, 1'b0, 16'h0, 1'b0, 1'b0};
        exp_tag = "R2";
        pending = 1;
        // R2 bank 3, register 7 -> 1Fh
        step(3'd0, 3'd7, 2'd3, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0, 8'h00);
        // R2 bank 2, register 0 -> 10h
        step(3'd0, 3'd0, 2'd2, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0, 8'h00);
        // R11 register-to-register move
        step(3'd0, 3'd3, 2'd1, 1'b1, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0, 8'h00);
        // R3 direct FFh
        step(3'd1, 3'd0, 2'd0, 1'b0, 8'hFF, 8'h00, 8'h00, 8'h00, 16'h0, 8'h00);
        // R4 indirect through register 1
        step(3'd2, 3'd1, 2'd0, 1'b0, 8'h00, 8'h00, 8'h40, 8'h7E, 16'h0, 8'h00);
        // R5 indirect through register 2
        step(3'd2, 3'd2, 2'd0, 1'b0, 8'h00, 8'h00, 8'h40, 8'h7E, 16'h0, 8'h00);
        // R5 external pointer through register 7
        step(3'd3, 3'd7, 2'd0, 1'b0, 8'h00, 8'h00, 8'h40, 8'h7E, 16'h0, 8'h00);
        // R6 external through register 0 -> 00C3h
        step(3'd3, 3'd0, 2'd0, 1'b0, 8'h00, 8'h00, 8'hC3, 8'h7E, 16'h0, 8'h00);
        // R7 full 16-bit external address
        step(3'd4, 3'd0, 2'd0, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 16'hFEDC, 8'h00);
        // R8 wrap: FFF0 + F0 -> 00E0
        step(3'd5, 3'd0, 2'd0, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 16'hFFF0, 8'hF0);
        // R8 unsigned index: 2000 + 80 -> 2080
        step(3'd5, 3'd0, 2'd0, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 16'h2000, 8'h80);
        // R9 short immediate with a high byte present that must be ignored
        step(3'd6, 3'd0, 2'd0, 1'b0, 8'h85, 8'hAA, 8'h00, 8'h00, 16'h0, 8'h00);
        // R10 wide immediate 2000h
        step(3'd7, 3'd0, 2'd0, 1'b0, 8'h00, 8'h20, 8'h00, 8'h00, 16'h0, 8'h00);
        // R12 pair flag outside register mode has no effect
        step(3'd1, 3'd4, 2'd1, 1'b1, 8'h3C, 8'h00, 8'h00, 8'h00, 16'h0, 8'h00);
        // R12 back-to-back mode changes, random mix
        for (int i = 0; i < 400; i++) begin
            step(3'($urandom), 3'($urandom), 2'($urandom), 1'($urandom),
                 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom),
                 (i % 4 == 0) ? (16'hFF00 | 16'($urandom_range(255))) : 16'($urandom),
                 8'($urandom));
        end
        step(3'd1, 3'd0, 2'd0, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0, 8'h00);
        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule